// File: doc/BRIEF.md
# Full-Period Pseudorandom Watermark Generator

This block produces the pseudorandom stream from which a ternary image watermark is derived. It is an 8-bit shift register with one-to-many XOR feedback. The feedback is altered so that the register walks through every one of the 256 possible values before it repeats. This includes the all-zero value, which plain XOR feedback would never leave. As a result, any 8-bit key can be used as a seed, including zero.

A controller loads the key into the register with a load strobe. It then raises the advance input once for each pixel. On every clock the block presents the current register value and a ternary symbol in the range 0 to 2, taken from the two low bits of that value. If a load and an advance occur in the same cycle, the load takes priority.

Top module: `wm_lfsr_gen`

## Requirements
- R1: A synchronous active-high reset sets the register to 0x01 on the clock edge where reset is sampled high. The symbol output is then 1.
- R2: When loadKey is high at a rising edge, the register takes the value of key on that edge, whatever advance is.
- R3: When neither loadKey nor advance is high at a rising edge, the register keeps its value.
- R4: When advance is high and loadKey is low at a rising edge, the register s becomes {s[6:0],0} XOR (f ? 0x71 : 0x00), where f = s[7] XOR (s[6:0] == 0). Bit 7 is the most significant bit, and 0x71 is the tap mask for x^8+x^6+x^5+x^4+1.
- R5: The modified feedback splices the zero state into the cycle. Advancing from 0x80 gives 0x00, and advancing from 0x00 gives 0x71.
- R6: Starting from any value, 256 consecutive advances return the register to that value, and the 256 values visited on the way are all distinct.
- R7: The symbol output equals the register's bits [1:0] when they are 0, 1 or 2, and equals 0 when they are 3. It is never 3.
- R8: A zero key is a legal seed. After it is loaded, the register advances normally and does not stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the default seed |
| loadKey | input | 1 | Copies key into the register |
| key | input | 8 | Seed value |
| advance | input | 1 | Steps the register once |
| lfsrState | output | 8 | Current register value |
| wmSymbol | output | 2 | Ternary watermark symbol, 0 to 2 |

## Verification
The bench builds the block with its default parameters: an 8-bit width, tap mask 0x71 and reset seed 0x01. With these values the whole cycle is only 256 advances long, so the bench can walk the complete period several times from different seeds, including zero and the value just before the spliced zero state. It can also tick off every state in a table. Random mixes of load, advance and idle cycles exercise the priority and hold rules around these walks.

// File: rtl/wm_lfsr_pkg.sv
package wm_lfsr_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } lfsr_ctrl_t;
endpackage

// File: rtl/wm_lfsr_ctrl.sv
module wm_lfsr_ctrl
  import wm_lfsr_pkg::*;
(
  input  logic       loadKey,
  input  logic       advance,
  output lfsr_ctrl_t ctrl
);
  // Load wins over a step requested in the same cycle.
  always_comb begin
    ctrl.load = loadKey;
    ctrl.step = advance & ~loadKey;
  end
endmodule

// File: rtl/wm_lfsr_dp.sv
module wm_lfsr_dp
  import wm_lfsr_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] TAP_MASK   = 8'h71,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsr_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] key,
  output logic [WIDTH-1:0] state,
  output logic [1:0]       symbol
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] nextState;
  logic             lowZero;
  logic             feedback;

  // The NOR of the low bits splices the all-zero value into the cycle.
  assign lowZero  = ~|stateQ[MSB-1:0];
  assign feedback = stateQ[MSB] ^ lowZero;
  assign shifted  = {stateQ[MSB-1:0], 1'b0};

  // One-to-many feedback: the feedback bit is XORed into each tap position.
  for (genvar b = 0; b < WIDTH; b++) begin : g_tap
    if (TAP_MASK[b]) begin : g_on
      assign nextState[b] = shifted[b] ^ feedback;
    end else begin : g_off
      assign nextState[b] = shifted[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            stateQ <= RESET_SEED;
    else if (ctrl.load) stateQ <= key;
    else if (ctrl.step) stateQ <= nextState;
  end

  assign state  = stateQ;
  assign symbol = (stateQ[1:0] == 2'd3) ? 2'd0 : stateQ[1:0];
endmodule

// File: rtl/wm_lfsr_gen.sv
module wm_lfsr_gen
  import wm_lfsr_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] TAP_MASK   = 8'h71,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadKey,
  input  logic [WIDTH-1:0] key,
  input  logic             advance,
  output logic [WIDTH-1:0] lfsrState,
  output logic [1:0]       wmSymbol
);
  lfsr_ctrl_t ctrl;

  wm_lfsr_ctrl u_ctrl (
    .loadKey (loadKey),
    .advance (advance),
    .ctrl    (ctrl)
  );

  wm_lfsr_dp #(
    .WIDTH      (WIDTH),
    .TAP_MASK   (TAP_MASK),
    .RESET_SEED (RESET_SEED)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .key    (key),
    .state  (lfsrState),
    .symbol (wmSymbol)
  );
endmodule

// File: rtl/wm_lfsr_chk.sv
module wm_lfsr_chk #(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] TAP_MASK   = 8'h71,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             loadKey,
  input logic [WIDTH-1:0] key,
  input logic             advance,
  input logic [WIDTH-1:0] lfsrState,
  input logic [1:0]       wmSymbol
);
  function automatic logic [WIDTH-1:0] refStep(input logic [WIDTH-1:0] s);
    logic f;
    f = s[WIDTH-1] ^ (s[WIDTH-2:0] == '0);
    return {s[WIDTH-2:0], 1'b0} ^ (f ? TAP_MASK : '0);
  endfunction

  p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lfsrState == RESET_SEED);

  p_load_key_r2: assert property (@(posedge clk) disable iff (rst)
    loadKey |=> lfsrState == $past(key));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!loadKey && !advance) |=> $stable(lfsrState));

  p_step_rule_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && !loadKey) |=> lfsrState == refStep($past(lfsrState)));

  p_zero_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && !loadKey && lfsrState == '0) |=> lfsrState != '0);

  p_symbol_range_r7: assert property (@(posedge clk) disable iff (rst)
    wmSymbol != 2'd3);

  p_symbol_map_r7: assert property (@(posedge clk) disable iff (rst)
    (lfsrState[1:0] != 2'd3) |-> wmSymbol == lfsrState[1:0]);
endmodule

bind wm_lfsr_gen wm_lfsr_chk #(
  .WIDTH      (WIDTH),
  .TAP_MASK   (TAP_MASK),
  .RESET_SEED (RESET_SEED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .loadKey   (loadKey),
  .key       (key),
  .advance   (advance),
  .lfsrState (lfsrState),
  .wmSymbol  (wmSymbol)
);

// File: tb/sim_wm_lfsr_gen.sv
`timescale 1ns/1ps
module sim_wm_lfsr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadKey = 1'b0;
  logic [7:0] key = 8'h00;
  logic       advance = 1'b0;
  logic [7:0] lfsrState;
  logic [1:0] wmSymbol;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  logic [7:0] expState = 8'h01;

  always #10 clk = ~clk;

  wm_lfsr_gen u0 (
    .clk(clk), .rst(rst), .loadKey(loadKey), .key(key),
    .advance(advance), .lfsrState(lfsrState), .wmSymbol(wmSymbol)
  );

  // Polynomial x^8+x^6+x^5+x^4+1, written bit by bit.
  function automatic logic [7:0] nextOf(input logic [7:0] s);
    logic f;
    logic [7:0] n;
    f = s[7] ^ (s[6:0] == 7'd0);
    n[0] = f;
    n[1] = s[0];
    n[2] = s[1];
    n[3] = s[2];
    n[4] = s[3] ^ f;
    n[5] = s[4] ^ f;
    n[6] = s[5] ^ f;
    n[7] = s[6];
    return n;
  endfunction

  function automatic logic [1:0] symOf(input logic [7:0] s);
    return (s[1:0] == 2'b11) ? 2'd0 : s[1:0];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic [7:0] k, input logic adv, input string req);
    @(negedge clk);
    loadKey = ld; key = k; advance = adv;
    @(posedge clk);
    #2;
    if (ld) expState = k;
    else if (adv) expState = nextOf(expState);
    check(req, lfsrState, expState);
    check("R7", {6'd0, wmSymbol}, {6'd0, symOf(expState)});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; loadKey = 1'b0; advance = 1'b0;
    @(posedge clk);
    #2;
    expState = 8'h01;
    check("R1", lfsrState, 8'h01);
    check("R1", {6'd0, wmSymbol}, 8'd1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fullPeriod(input logic [7:0] seed);
    bit seen [256];
    cycle(1'b1, seed, 1'b0, "R2");
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    seen[seed] = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      cycle(1'b0, 8'h00, 1'b1, "R4");
      if (i < 256) begin
        nChecks++;
        if (seen[lfsrState]) begin
          nFails++;
          $display("FAIL R6: actual %02h repeated at step %0d expected unseen", lfsrState, i);
        end
        seen[lfsrState] = 1'b1;
      end else begin
        check("R6", lfsrState, seed);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    // R8: zero key advances out of zero.
    cycle(1'b1, 8'h00, 1'b0, "R8");
    cycle(1'b0, 8'h00, 1'b1, "R8");
    check("R8", lfsrState, 8'h71);
    // R5: 0x40 -> 0x80 -> 0x00 -> 0x71.
    cycle(1'b1, 8'h40, 1'b0, "R2");
    cycle(1'b0, 8'h00, 1'b1, "R5");
    check("R5", lfsrState, 8'h80);
    cycle(1'b0, 8'h00, 1'b1, "R5");
    check("R5", lfsrState, 8'h00);
    cycle(1'b0, 8'h00, 1'b1, "R5");
    check("R5", lfsrState, 8'h71);
    // R2: load wins over advance.
    cycle(1'b1, 8'hC3, 1'b1, "R2");
    check("R2", lfsrState, 8'hC3);
    // R3: idle cycles hold.
    for (int i = 0; i < 4; i++) cycle(1'b0, 8'hFF, 1'b0, "R3");
    check("R3", lfsrState, 8'hC3);
    // R6: full walks from several seeds.
    fullPeriod(8'h00);
    fullPeriod(8'h80);
    fullPeriod(8'h5A);
    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      cycle(r[3:0] == 4'd0, r[15:8], r[5], "R4");
    end
    // R1: reset mid-run.
    cycle(1'b1, 8'hEE, 1'b0, "R2");
    doReset();
    cycle(1'b0, 8'h00, 1'b1, "R4");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule